// File: doc/BRIEF.md
# Triple-Redundant Voted Reset Supervisor

This block produces the system reset for a processor from three identical supervisor slices whose reset requests are combined by a two-out-of-three majority voter. Each slice watches its own supply-good comparator output, which it brings into the clock domain through a two-flop synchronizer. It holds a reset request while the supply is bad and for a fixed hold time after the supply becomes good, whether this is the first power-up or a recovery from a brownout. It also runs a watchdog that the processor keeps quiet with a burst of consecutive writes to an address belonging only to that slice.

A watchdog reset is issued only when at least two slices have timed out. All three slices then hold their request for the watchdog reset time. When that time ends, every watchdog window and burst counter starts again at the same moment. A prescaler parameter turns clock cycles into timer ticks, so the same RTL can run with millisecond ticks in silicon and very short ticks in simulation. Per-slice fault inputs force a slice's request high or low so that tests can confirm that one bad slice is always outvoted.

Top module: `tmr_reset_supervisor`

## Requirements
- R1: `sys_rst` is active high and registered. It equals the 2-of-3 majority of the slice requests one clock later, and it is 1 while `rst_n` is low.
- R2: After a slice's synchronized supply-good first rises, that slice requests reset for HOLD_TICKS ticks (HOLD_TICKS*TICK_DIV clock cycles).
- R3: While a slice's supply-good is low, the slice requests reset. After the supply recovers, the slice holds its request for the same HOLD_TICKS ticks as at power-up. A drop of two cycles is enough to trigger this.
- R4: Slice i accepts writes to address WD_BASE+i. KICKS (default 10) consecutive writes to that address restart its watchdog window of WIN_TICKS ticks. If every slice gets such a burst within each window, no reset occurs.
- R5: When two or more slices let their window expire without a full burst, `sys_rst` rises within a few cycles and stays high for WDRST_TICKS*TICK_DIV cycles.
- R6: A write to any address other than the slice's own, including another slice's address, clears that slice's consecutive-write count to zero.
- R7: When a watchdog reset ends, all three windows and counts restart together. The next watchdog reset can come no sooner than one full window later.
- R8: Forcing one slice's request high (`flt_force_req`) or low (`flt_force_idle`) does not change `sys_rst`. Forcing two slices high asserts it.
- R9: A watchdog timeout in one slice alone does not assert `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgood_raw | input | 3 | Asynchronous supply-good comparator output, one bit per slice |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Processor write address |
| flt_force_req | input | 3 | Fault injection: force a slice's request high |
| flt_force_idle | input | 3 | Fault injection: force a slice's request low |
| sys_rst | output | 1 | Voted, registered, active-high system reset |

## Verification
A corrupted hold counter or a lost supply-good edge in one slice cannot reach `sys_rst` on its own. It shows only when a second slice is also forced or browned out, so the bench pairs single-slice faults with brownouts and forced requests. A wrong consecutive-write count or window count shows as a watchdog reset that comes one window too early or too late. The broken-burst and restart-after-reset sequences are timed so that either error moves the `sys_rst` edge across a sampling point within about one window of 120 cycles.

// File: rtl/tmr_rst_pkg.sv
package tmr_rst_pkg;
  localparam int unsigned NUM_SLICES = 3;

  function automatic logic maj3(input logic [NUM_SLICES-1:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/trs_sync2.sv
module trs_sync2 #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/trs_slice.sv
module trs_slice #(
  parameter int unsigned TICK_DIV    = 125000,
  parameter int unsigned HOLD_TICKS  = 100,
  parameter int unsigned WIN_TICKS   = 1400,
  parameter int unsigned WDRST_TICKS = 1000,
  parameter int unsigned KICKS       = 10,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgood,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wd_vote,
  output logic              req,
  output logic              wd_flag,
  output logic              wd_busy
);
  localparam int unsigned PW = $clog2(TICK_DIV + 1);
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
  localparam int unsigned WW = $clog2(WIN_TICKS + 1);
  localparam int unsigned RW = $clog2(WDRST_TICKS + 1);
  localparam int unsigned KW = $clog2(KICKS + 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [HW-1:0] hold_q, hold_d;
  logic [WW-1:0] win_q, win_d;
  logic [KW-1:0] kick_q, kick_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          flag_q, flag_d;
  logic          busy_q, busy_d;

  logic tick, hold_act, wd_start, run, hit, miss, satisfied;

  always_comb begin
    tick      = (pre_q == PW'(TICK_DIV - 1));
    hold_act  = !pgood || (hold_q != '0);
    wd_start  = wd_vote && !busy_q;
    run       = !hold_act && !busy_q && !wd_start;
    hit       = wr_en && (wr_addr == MY_ADDR);
    miss      = wr_en && (wr_addr != MY_ADDR);
    satisfied = hit && (kick_q == KW'(KICKS - 1));

    // prescaler, realigned on supply loss and watchdog reset start
    if (!pgood || wd_start || tick) pre_d = '0;
    else                            pre_d = pre_q + 1'b1;

    // power-up / brownout hold
    if (!pgood)                      hold_d = HW'(HOLD_TICKS);
    else if (tick && hold_q != '0)   hold_d = hold_q - 1'b1;
    else                             hold_d = hold_q;

    // watchdog reset duration
    busy_d = busy_q;
    rcnt_d = rcnt_q;
    if (wd_start) begin
      busy_d = 1'b1;
      rcnt_d = RW'(WDRST_TICKS);
    end else if (busy_q && tick) begin
      if (rcnt_q <= RW'(1)) begin
        busy_d = 1'b0;
        rcnt_d = '0;
      end else begin
        rcnt_d = rcnt_q - 1'b1;
      end
    end

    // watchdog window and burst counter
    win_d  = win_q;
    kick_d = kick_q;
    flag_d = flag_q;
    if (!run) begin
      win_d  = '0;
      kick_d = '0;
      flag_d = 1'b0;
    end else if (satisfied) begin
      win_d  = '0;
      kick_d = '0;
      flag_d = 1'b0;
    end else begin
      if (hit)       kick_d = kick_q + 1'b1;
      else if (miss) kick_d = '0;
      if (tick && !flag_q) begin
        if (win_q == WW'(WIN_TICKS - 1)) flag_d = 1'b1;
        else                             win_d  = win_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      hold_q <= HW'(HOLD_TICKS);
      win_q  <= '0;
      kick_q <= '0;
      rcnt_q <= '0;
      flag_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      hold_q <= hold_d;
      win_q  <= win_d;
      kick_q <= kick_d;
      rcnt_q <= rcnt_d;
      flag_q <= flag_d;
      busy_q <= busy_d;
    end
  end

  assign req     = hold_act || busy_q;
  assign wd_flag = flag_q;
  assign wd_busy = busy_q;
endmodule

// File: rtl/trs_voter.sv
module trs_voter
  import tmr_rst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SLICES-1:0] req,
  input  logic [NUM_SLICES-1:0] flag,
  output logic                  wd_vote,
  output logic                  sys_rst
);
  logic rst_d;

  always_comb begin
    wd_vote = maj3(flag);
    rst_d   = maj3(req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst <= 1'b1;
    else        sys_rst <= rst_d;
  end
endmodule

// File: rtl/tmr_reset_supervisor.sv
module tmr_reset_supervisor
  import tmr_rst_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 125000,
  parameter int unsigned HOLD_TICKS  = 100,
  parameter int unsigned WIN_TICKS   = 1400,
  parameter int unsigned WDRST_TICKS = 1000,
  parameter int unsigned KICKS       = 10,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] WD_BASE = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pgood_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [2:0]        flt_force_req,
  input  logic [2:0]        flt_force_idle,
  output logic              sys_rst
);
  logic [NUM_SLICES-1:0] pgood_s;
  logic [NUM_SLICES-1:0] raw_req, raw_flag, slice_busy;
  logic [NUM_SLICES-1:0] slice_req, slice_flag;
  logic                  wd_vote;

  trs_sync2 #(.W(NUM_SLICES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pgood_raw), .q(pgood_s)
  );

  for (genvar gi = 0; gi < NUM_SLICES; gi++) begin : g_slice
    trs_slice #(
      .TICK_DIV(TICK_DIV), .HOLD_TICKS(HOLD_TICKS), .WIN_TICKS(WIN_TICKS),
      .WDRST_TICKS(WDRST_TICKS), .KICKS(KICKS), .ADDR_W(ADDR_W),
      .MY_ADDR(WD_BASE + ADDR_W'(gi))
    ) u_slice (
      .clk(clk), .rst_n(rst_n), .pgood(pgood_s[gi]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wd_vote(wd_vote),
      .req(raw_req[gi]), .wd_flag(raw_flag[gi]), .wd_busy(slice_busy[gi])
    );

    always_comb begin
      if (flt_force_req[gi])       slice_req[gi] = 1'b1;
      else if (flt_force_idle[gi]) slice_req[gi] = 1'b0;
      else                         slice_req[gi] = raw_req[gi];
      slice_flag[gi] = raw_flag[gi] && !flt_force_idle[gi];
    end
  end

  trs_voter u_voter (
    .clk(clk), .rst_n(rst_n), .req(slice_req), .flag(slice_flag),
    .wd_vote(wd_vote), .sys_rst(sys_rst)
  );
endmodule

// File: rtl/tmr_reset_supervisor_chk.sv
module tmr_reset_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pgood_s,
  input logic [2:0] slice_req,
  input logic [2:0] slice_busy,
  input logic [2:0] flt_force_req,
  input logic [2:0] flt_force_idle,
  input logic       wd_vote,
  input logic       sys_rst
);
  assert_vote_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slice_req) >= 2) |=> sys_rst);

  assert_vote_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slice_req) < 2) |=> !sys_rst);

  assert_wd_all_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_vote |=> (&slice_busy));

  for (genvar gi = 0; gi < 3; gi++) begin : g_chk
    assert_hold_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pgood_s[gi]) && !flt_force_idle[gi]) |-> slice_req[gi]);

    assert_brownout_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgood_s[gi] && !flt_force_idle[gi]) |-> slice_req[gi]);

    assert_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flt_force_req[gi] |-> slice_req[gi]);
  end
endmodule

bind tmr_reset_supervisor tmr_reset_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pgood_s(pgood_s), .slice_req(slice_req),
  .slice_busy(slice_busy), .flt_force_req(flt_force_req),
  .flt_force_idle(flt_force_idle), .wd_vote(wd_vote), .sys_rst(sys_rst)
);

// File: tb/tmr_reset_supervisor_tb.sv
module tmr_reset_supervisor_tb;
  localparam int unsigned DIV    = 4;
  localparam int unsigned HOLD   = 10;
  localparam int unsigned WIN    = 30;
  localparam int unsigned WDRST  = 20;
  localparam int unsigned KICKS  = 10;
  localparam int unsigned AW     = 16;
  localparam logic [AW-1:0] BASE  = 16'hFF00;
  localparam logic [AW-1:0] OTHER = 16'h1234;

  // vector: {pgood[2:0], force_req[2:0], force_idle[2:0], expected sys_rst}
  localparam logic [9:0] VEC [0:8] = '{
    10'b111_000_000_0,
    10'b111_001_000_0,
    10'b111_011_000_1,
    10'b111_000_001_0,
    10'b111_000_011_0,
    10'b111_100_010_0,
    10'b011_000_000_0,
    10'b011_001_000_1,
    10'b100_000_000_1
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    pgood_raw, flt_force_req, flt_force_idle;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          sys_rst;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;

  always #4 clk = ~clk;

  tmr_reset_supervisor #(
    .TICK_DIV(DIV), .HOLD_TICKS(HOLD), .WIN_TICKS(WIN), .WDRST_TICKS(WDRST),
    .KICKS(KICKS), .ADDR_W(AW), .WD_BASE(BASE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pgood_raw(pgood_raw), .wr_en(wr_en),
    .wr_addr(wr_addr), .flt_force_req(flt_force_req),
    .flt_force_idle(flt_force_idle), .sys_rst(sys_rst)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (sys_rst !== exp) begin
      fails++;
      $display("FAIL %s: sys_rst=%0b expected %0b at %0t", tag, sys_rst, exp, $time);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      wr_en = 1'b1; wr_addr = a;
      step(1);
    end
    wr_en = 1'b0;
  endtask

  task automatic kick_all();
    for (int s = 0; s < 3; s++) wr(BASE + AW'(s), KICKS);
  endtask

  // slices 0 and 1 get bursts of KICKS-1 preceded by a foreign write (R6)
  task automatic broken_round();
    wr(OTHER, 1); wr(BASE, KICKS - 1);
    wr(OTHER, 1); wr(BASE + AW'(1), KICKS - 1);
    wr(BASE + AW'(2), KICKS);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: bench hung, done=%0b expected 1", done);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pgood_raw = 3'b000; wr_en = 1'b0; wr_addr = '0;
    flt_force_req = '0; flt_force_idle = '0;
    step(5);
    chk(1'b1, "R1 reset value");
    rst_n = 1'b1;
    step(20);
    chk(1'b1, "R3 supply low");

    // R2 power-up hold: ~HOLD*DIV+3 cycles
    pgood_raw = 3'b111;
    step(30);
    chk(1'b1, "R2 hold active");
    step(20);
    chk(1'b0, "R2 hold released");

    // table of fault / brownout combinations (R1, R3, R8)
    for (int v = 0; v < 9; v++) begin
      kick_all();
      pgood_raw      = VEC[v][9:7];
      flt_force_req  = VEC[v][6:4];
      flt_force_idle = VEC[v][3:1];
      step(6);
      chk(VEC[v][0], $sformatf("R8 vector %0d", v));
    end

    // R3 recovery after brownout of two slices
    pgood_raw = 3'b111; flt_force_req = '0; flt_force_idle = '0;
    kick_all();
    chk(1'b1, "R3 re-hold after recovery");
    kick_all();
    chk(1'b0, "R3 re-hold released");
    kick_all();

    // R3 two-cycle glitch on all supplies
    pgood_raw = 3'b000;
    step(2);
    pgood_raw = 3'b111;
    step(5);
    chk(1'b1, "R3 glitch seen");
    step(25);
    chk(1'b1, "R3 glitch hold");
    step(25);
    chk(1'b0, "R3 glitch released");

    // R6/R5: broken bursts in slices 0 and 1
    kick_all();
    broken_round(); broken_round(); broken_round();
    step(6);
    chk(1'b0, "R6 before window end");
    step(24);
    chk(1'b1, "R5 R6 watchdog reset");
    step(60);
    chk(1'b1, "R5 reset duration");
    step(20);
    chk(1'b0, "R5 reset ended");

    // R7: windows restart together after the watchdog reset
    step(95);
    chk(1'b0, "R7 full window after restart");
    step(25);
    chk(1'b1, "R7 next timeout");
    step(90);
    chk(1'b0, "R7 second reset ended");

    // R9: only slice 0 starves
    for (int r = 0; r < 8; r++) begin
      wr(BASE + AW'(1), KICKS);
      wr(BASE + AW'(2), KICKS);
    end
    chk(1'b0, "R9 single timeout outvoted");

    // R4: steady bursts across several windows
    for (int r = 0; r < 6; r++) kick_all();
    chk(1'b0, "R4 kept quiet");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule